// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the word address for a synchronous burst memory array. A burst opens when one of two active-low address strobes is seen low at a rising clock edge. One strobe comes from the processor side and the other from the controller side. At that edge the external address is captured. Once the burst is open, the two lowest address bits move through a four-beat sequence. They step once for every edge at which the active-low advance input is low, and they stay put otherwise, which lets the system insert wait states.

A static ordering input picks between two sequences. The interleaved order flips the low bits with the beat number. The linear order adds the beat number and wraps inside the aligned four-word block. The upper address bits never change inside a burst. The processor strobe only counts while the primary chip select is active. The controller strobe always counts.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `wordAddr` is all zeros.
- R2: If `ctrlStrobeN` is low at a rising edge, `addrIn` is captured at that edge. From the next cycle, `wordAddr` equals the captured address (beat 0).
- R3: If `procStrobeN` is low at an edge with `chipSelN` low, it loads `addrIn` in the same way as R2. If `chipSelN` is high, the processor strobe has no effect, so the output behaves as if the strobe were high.
- R4: If no load happens and `advanceN` is low at an edge, the beat number increases by one, modulo 4.
- R5: If no load happens and `advanceN` is high, the beat number and the captured address are held. `wordAddr` does not change.
- R6: A load at an edge takes priority over advance. The address is captured and the beat returns to 0.
- R7: With `interleaveMode` = 1, the low two bits of `wordAddr` equal the captured low two bits XOR the beat number.
- R8: With `interleaveMode` = 0, the low two bits equal the captured low two bits plus the beat number, modulo 4.
- R9: Bits [ADDR_W-1:2] of `wordAddr` change only at a load edge.
- R10: After four advances, the beat number wraps back to 0, so `wordAddr` returns to the captured address in both orderings.
- R11: The controller strobe loads whatever the level of `chipSelN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| procStrobeN | input | 1 | Processor-side burst start, active low, gated by chip select |
| ctrlStrobeN | input | 1 | Controller-side burst start, active low, never gated |
| advanceN | input | 1 | Active-low beat advance |
| chipSelN | input | 1 | Active-low primary chip select |
| interleaveMode | input | 1 | 1 = interleaved order, 0 = linear order |
| addrIn | input | ADDR_W | External start address |
| wordAddr | output | ADDR_W | Current word address for the array |

## Verification
The assertions assume that `interleaveMode` is static within a burst. The hold and linear-step properties therefore allow the output to move only when the mode level itself changes. The stimulus follows this rule: it changes the mode only in a cycle where a strobe loads a new address, and in such a cycle no step is taken. All other inputs are driven freely, including strobes that coincide with advance and processor strobes while the chip is deselected.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic load;   // capture external address, beat back to 0
    logic step;   // move to the next beat
  } burstCtl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      procStrobeN,
  input  logic      ctrlStrobeN,
  input  logic      advanceN,
  input  logic      chipSelN,
  output burstCtl_t ctl
);
  logic procLoad;
  logic ctrlLoad;

  always_comb begin
    procLoad = !procStrobeN && !chipSelN;
    ctrlLoad = !ctrlStrobeN;
    ctl.load = procLoad || ctrlLoad;
    ctl.step = !advanceN && !ctl.load;   // load has priority
  end

  // R3: a processor strobe with the chip deselected never starts a burst
  p_proc_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobeN && chipSelN) |-> !ctl.load);

  // R11: the controller strobe always loads
  p_ctrl_honoured_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlStrobeN |-> ctl.load);
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wordAddr
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  baseReg;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] lowBits;
  logic [BURST_W-1:0] baseLow;
  logic [UPPER_W-1:0] baseHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      beatCnt <= '0;
    end else if (ctl.load) begin
      baseReg <= addrIn;
      beatCnt <= '0;
    end else if (ctl.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign baseLow  = baseReg[BURST_W-1:0];
  assign baseHigh = baseReg[ADDR_W-1:BURST_W];

  always_comb begin
    if (interleaveMode) lowBits = baseLow ^ beatCnt;
    else                lowBits = baseLow + beatCnt;
  end

  assign wordAddr = {baseHigh, lowBits};

  // R6: control never asks for load and step together
  p_load_excl_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.step));

  // R2: the cycle after a load shows the captured address
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (wordAddr == $past(addrIn)));

  // R5: with no load and no step, the address is frozen unless the mode pin moved
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> (!$stable(interleaveMode) || $stable(wordAddr)));

  // R9: the upper bits change only at a load
  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> (wordAddr[ADDR_W-1:BURST_W] == $past(wordAddr[ADDR_W-1:BURST_W])));

  // R8: a linear step adds one to the low bits, modulo the block size
  p_linear_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !interleaveMode) |=>
      (interleaveMode || wordAddr[BURST_W-1:0] == BURST_W'($past(wordAddr[BURST_W-1:0]) + 1'b1)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipSelN,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] wordAddr
);
  burstCtl_t ctl;

  burst_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .chipSelN    (chipSelN),
    .ctl         (ctl)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .interleaveMode (interleaveMode),
    .addrIn         (addrIn),
    .wordAddr       (wordAddr)
  );
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procStrobeN = 1'b1;
  logic ctrlStrobeN = 1'b1;
  logic advanceN = 1'b1;
  logic chipSelN = 1'b1;
  logic interleaveMode = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] wordAddr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference state
  int refBase = 0;
  int refBeat = 0;

  always #4 clk = ~clk;   // 125 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_burst_addr_gen (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipSelN(chipSelN), .interleaveMode(interleaveMode),
    .addrIn(addrIn), .wordAddr(wordAddr)
  );

  function automatic int expectedAddr();
    int low;
    if (interleaveMode) low = (refBase & 3) ^ refBeat;
    else                low = ((refBase & 3) + refBeat) % 4;
    return (refBase & ~3) | low;
  endfunction

  task automatic check(input string tag);
    int exp;
    exp = expectedAddr();
    tests++;
    if (int'(wordAddr) != exp) begin
      fails++;
      $display("FAIL %s: wordAddr=%h expected=%h", tag, wordAddr, exp[ADDR_W-1:0]);
    end
  endtask

  // drive at negedge, clock one edge, update reference, compare at next negedge
  task automatic cyc(input bit pN, input bit cN, input bit aN, input bit csN,
                     input bit mode, input int addr, input string tag);
    bit isLoad;
    procStrobeN = pN; ctrlStrobeN = cN; advanceN = aN; chipSelN = csN;
    interleaveMode = mode; addrIn = addr[ADDR_W-1:0];
    @(posedge clk);
    isLoad = !cN || (!pN && !csN);
    if (isLoad) begin
      refBase = addr & 16'hFFFF;
      refBeat = 0;
    end else if (!aN) begin
      refBeat = (refBeat + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        fails++;
        tests++;
        $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R2 + R8 + R10: controller load, linear order, full wrap
    cyc(1, 0, 1, 0, 0, 16'h1232, "R2 ctrl load");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, "R8 R10 linear step/wrap");
    // R5: wait states
    cyc(1, 1, 0, 0, 0, 0, "R4 advance");
    cyc(1, 1, 1, 0, 0, 0, "R5 hold");
    cyc(1, 1, 1, 1, 0, 0, "R5 hold deselected");
    // R3: processor strobe with chip deselected is ignored
    cyc(0, 1, 1, 1, 0, 16'h7777, "R3 proc ignored");
    cyc(0, 1, 0, 1, 0, 16'h5555, "R3 proc ignored, advance taken");
    // R3 + R7: processor load then interleaved sequence
    cyc(0, 1, 1, 0, 1, 16'hABC1, "R3 proc load");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 1, 0, "R7 R10 interleaved step/wrap");
    cyc(1, 1, 0, 0, 1, 0, "R7 step");
    // R11: controller strobe while deselected
    cyc(1, 0, 1, 1, 1, 16'h4402, "R11 ctrl load deselected");
    cyc(1, 1, 0, 1, 1, 0, "R7 step after R11 load");
    // R6: load with advance asserted
    cyc(1, 0, 0, 0, 1, 16'h0F0B, "R6 load beats advance");
    cyc(0, 1, 0, 0, 1, 16'h3003, "R6 proc load beats advance");
    cyc(1, 1, 0, 0, 1, 0, "R7 step");

    // R9: mixed run; mode changes only on load cycles
    for (int i = 0; i < 400; i++) begin
      bit pN, cN, aN, csN, m;
      int a;
      pN = ($urandom % 4) != 0;
      cN = ($urandom % 5) != 0;
      aN = ($urandom % 3) == 0;
      csN = $urandom % 2;
      a = $urandom % 65536;
      m = interleaveMode;
      if (!cN || (!pN && !csN)) m = $urandom % 2;
      cyc(pN, cN, aN, csN, m, a, "R9 mixed run");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule